// File: doc/BRIEF.md
# Power-of-Two Rate Enable Generator

This block slows a datapath without touching its clock. It counts cycles of the single core clock, which runs at 125 MHz by default, and from that count it makes a one-cycle clock-enable pulse. Downstream modules advance only in cycles where the pulse is high. Six rates are available, each half the one above it. On a 64-bit datapath, level 5 is full rate, equal to 8 Gbps, and level 0 is 1/32 of full rate, equal to 250 Mbps.

A rate selector outside this block decides the level. It presents the level index on a 3-bit binary code, where 0 is the slowest rate, together with a one-cycle change strobe. The new level is captured in a register. The rate therefore changes one core cycle after the decision, and the divide counter starts again from zero at that point. The first enable at the new rate comes one full new period later, so no shortened period is ever produced. The block also reports the level that is currently in effect.

All pins are plain control and status pins. No data passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `rate_enable_gen`

## Requirements
- R1: While reset is held and just after it is released, `lvl_active` is 0 and `rate_en` is low. With no strobe, the first `rate_en` pulse appears after the 32nd rising clock edge following release.
- R2: At a clock edge where `lvl_strobe` is high, `lvl_active` takes the requested level. The new value is visible in the following cycle.
- R3: At level k, for k from 0 to 4, `rate_en` is high for exactly one cycle in every 2^(5-k) cycles.
- R4: At level 5, `rate_en` is high on every cycle, starting with the first cycle after the edge that loaded the level.
- R5: In the cycle after a strobe edge, `rate_en` is low. The first pulse at the new level appears exactly 2^(5-k) cycles after that edge, whatever phase the counter had reached before.
- R6: A strobe that requests the level already in effect still restarts the period, as described in R5.
- R7: A requested code of 6 or 7 saturates to level 5.
- R8: While `lvl_strobe` is low, changes on `lvl_req` have no effect on `lvl_active` or on the timing of `rate_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_req | input | 3 | Requested rate level, binary; 0 is slowest, 5 is full rate |
| lvl_strobe | input | 1 | One-cycle strobe that loads `lvl_req` |
| rate_en | output | 1 | Registered clock-enable pulse at the active rate |
| lvl_active | output | 3 | Level currently in effect |

## Verification
The bench sweeps every request code from 0 to 7, starting each one with a strobe. It checks the enable on every cycle for three periods. This shows whether the period doubles correctly at each level and whether codes 6 and 7 saturate to full rate. A separate run follows reset release for 40 cycles, which shows the first pulse landing exactly on edge 32. Strobes issued in the middle of a period, strobes that repeat the current level, and wiggling of `lvl_req` while the strobe is low show the difference between a true counter restart and a counter that keeps its old phase. They also show that the request code is sampled only when the strobe is high.

// File: rtl/rate_pkg.sv
package rate_pkg;
  localparam int unsigned RATE_LEVELS_DEF = 6;

  function automatic int unsigned lvl_bits(input int unsigned levels);
    return (levels < 2) ? 1 : $clog2(levels);
  endfunction
endpackage

// File: rtl/rate_level_reg.sv
module rate_level_reg #(
  parameter int unsigned LEVELS = 6,
  parameter int unsigned LVL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] req,
  input  logic             req_vld,
  output logic [LVL_W-1:0] lvl_q
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS - 1);

  logic [LVL_W-1:0] req_sat;
  always_comb req_sat = (req > TOP) ? TOP : req;

  always_ff @(posedge clk) begin
    if (!rst_n)       lvl_q <= '0;
    else if (req_vld) lvl_q <= req_sat;
  end

  // R8: level only moves on a strobe
  a_r8_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> $stable(lvl_q));
  // R7: the active level never leaves the legal range
  a_r7_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= TOP);
endmodule

// File: rtl/rate_div_counter.sv
module rate_div_counter #(
  parameter int unsigned LEVELS = 6,
  parameter int unsigned LVL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic             restart,
  output logic             tick
);
  localparam int unsigned CNT_W = LEVELS - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = {CNT_W{1'b1}} >> lvl;
    tick  = !restart && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R3: the counter stays inside the current period
  a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
  // R5: a restart always brings the counter back to zero
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/rate_en_out.sv
module rate_en_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= tick;
  end
endmodule

// File: rtl/rate_enable_gen.sv
module rate_enable_gen #(
  parameter int unsigned LEVELS = rate_pkg::RATE_LEVELS_DEF,
  parameter int unsigned LVL_W  = rate_pkg::lvl_bits(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_req,
  input  logic             lvl_strobe,
  output logic             rate_en,
  output logic [LVL_W-1:0] lvl_active
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS - 1);

  logic tick;

  rate_level_reg #(.LEVELS(LEVELS), .LVL_W(LVL_W)) level_i (
    .clk(clk), .rst_n(rst_n), .req(lvl_req), .req_vld(lvl_strobe),
    .lvl_q(lvl_active));

  rate_div_counter #(.LEVELS(LEVELS), .LVL_W(LVL_W)) div_i (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_active), .restart(lvl_strobe),
    .tick(tick));

  rate_en_out out_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_q(rate_en));

  // R5: enable is low in the cycle after a switch
  a_r5_low_after_switch: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_strobe |=> !rate_en);
  // R4: full rate keeps the enable high
  a_r4_full_rate_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_active == TOP && !lvl_strobe) |=> rate_en);
  // R3: at reduced rates the pulse is a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_en && lvl_active != TOP) |=> !rate_en);
  // R2: a strobe loads the saturated request
  a_r2_strobe_loads: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_strobe |=> (lvl_active == (($past(lvl_req) > TOP) ? TOP : $past(lvl_req))));
endmodule

// File: tb/rate_enable_gen_tb_top.sv
module rate_enable_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] lvl_req = '0;
  logic       lvl_strobe = 1'b0;
  logic       rate_en;
  logic [2:0] lvl_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rate_enable_gen dut_i (
    .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .lvl_strobe(lvl_strobe),
    .rate_en(rate_en), .lvl_active(lvl_active));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // strobe a code; returns after the loading edge, with the strobe dropped
  task automatic load(input int code);
    lvl_req = 3'(code); lvl_strobe = 1'b1;
    step();
    lvl_strobe = 1'b0;
  endtask

  function automatic int eff(input int code);
    return (code > 5) ? 5 : code;
  endfunction

  // check n cycles after a load edge (cycle 0 already sampled)
  task automatic follow(input string req, input int lvl, input int n);
    int per = 1 << (5 - lvl);
    for (int k = 1; k <= n; k++) begin
      step();
      chk(req, rate_en, (k % per == 0) ? 1 : 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 reset level", lvl_active, 0);
    chk("R1 reset enable", rate_en, 0);
    rst_n = 1'b1;
    chk("R1 after release", rate_en, 0);
    for (int k = 1; k <= 40; k++) begin
      step();
      chk("R1 first pulse", rate_en, (k == 32) ? 1 : 0);
    end

    // sweep every code: R2 R3 R4 R5 R7
    for (int code = 0; code < 8; code++) begin
      load(code);
      chk((code > 5) ? "R7 saturate" : "R2 level load", lvl_active, eff(code));
      chk("R5 low after switch", rate_en, 0);
      follow((eff(code) == 5) ? "R4 full rate" : "R3 period", eff(code),
             3 * (1 << (5 - eff(code))));
    end

    // R5: switch mid-period from level 0 to level 2
    load(0);
    repeat (13) step();
    load(2);
    chk("R5 mid switch level", lvl_active, 2);
    chk("R5 mid switch low", rate_en, 0);
    follow("R5 mid switch", 2, 24);

    // R6: same level restrobe restarts the period
    load(3);
    repeat (2) step();
    load(3);
    chk("R6 restrobe low", rate_en, 0);
    follow("R6 restart", 3, 12);

    // R8: request changes without strobe are ignored
    load(1);
    for (int k = 1; k <= 48; k++) begin
      lvl_req = 3'(k % 8);
      step();
      chk("R8 level kept", lvl_active, 1);
      chk("R8 timing kept", rate_en, (k % 16 == 0) ? 1 : 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule